// File: doc/BRIEF.md
# Aliased Video-Mode and Coprocessor-Reset Register Slice

This slice sits in front of a larger peripheral register space. It holds two 8-bit control registers: a video-mode byte and a coprocessor-reset byte. A byte access reaches either register on its own. A halfword or word access at the lower of the two addresses sees both registers at once, packed into a single 16-bit value. Every other access is passed unchanged to a downstream register port through a valid/ready handshake.

Before any decoding, the upstream address is cut down to its low 15 bits. Which register an access reaches depends on both this offset and the access size. The reset register keeps only bit 0 of whatever is written to it, and that bit drives the coprocessor reset line. A locally decoded access completes in the cycle it is presented and never shows up downstream. A write to a local register takes effect at the following clock edge.

Top module: `ctl_alias_slice`

## Requirements
- R1: Only the low 15 address bits are decoded. An access whose offset matches a local register is handled locally, whatever the upper address bits hold. The downstream address carries those 15 bits, with all bits above them zero.
- R2: A byte access (up_is_byte=1) at offset 0x2C01 reads or writes the video-mode register. A write takes wdata[7:0]. A read returns the register zero-extended in rdata[7:0].
- R3: A byte access at offset 0x2C00 reaches the reset register. A write keeps only wdata[0]. A read returns {all zeros, reset bit}.
- R4: A non-byte read (up_is_byte=0) at offset 0x2C00 returns rdata[15:8]=video mode, rdata[7:0]={7'b0, reset bit}, and zero in all higher bits.
- R5: A non-byte write at offset 0x2C00 loads video mode from wdata[15:8] and the reset bit from wdata[0], both in the same cycle.
- R6: coproc_rst equals the stored reset bit. It changes only at the clock edge that ends a write to offset 0x2C00, of either size.
- R7: All other accesses pass through, including a non-byte access at 0x2C01. For these, dn_valid=up_valid, and write, size and write data are copied to the downstream port. up_ready follows dn_ready, and up_rdata equals dn_rdata.
- R8: A local access gives up_ready=1 in the same cycle and keeps dn_valid at 0.
- R9: Reset clears both registers, so coproc_rst is 0 and a packed read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream access request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_is_byte | input | 1 | 1 = byte access, 0 = halfword/word access |
| up_addr | input | ADDR_W | Upstream byte address |
| up_wdata | input | DATA_W | Upstream write data |
| up_ready | output | 1 | Access completes this cycle |
| up_rdata | output | DATA_W | Read data, valid when up_valid and up_ready are high |
| dn_valid | output | 1 | Downstream request |
| dn_write | output | 1 | Downstream write flag |
| dn_is_byte | output | 1 | Downstream size flag |
| dn_addr | output | ADDR_W | Downstream address, 15-bit offset zero-extended |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_ready | input | 1 | Downstream completion |
| dn_rdata | input | DATA_W | Downstream read data |
| coproc_rst | output | 1 | Coprocessor reset state, bit 0 of the reset register |

## Verification
The bench targets the size-dependent decode. A non-byte access at 0x2C01 must go downstream; a design that decodes by address alone would instead answer it locally and swallow the request. Addresses with upper bits set and offsets that match the local ones catch a design that compares the full address, which would wrongly forward those accesses. Writing 0xFF to the reset byte and reading it back exposes a design that stores all eight bits, since the read returns more than bit 0. A packed write with distinct byte values catches swapped halves. Random downstream ready and read data expose any mix-up in the handshake or read mux.

// File: rtl/ctl_alias_slice.sv
module ctl_alias_slice #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 15,
  parameter logic [14:0] BASE = 15'h2C00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic              up_is_byte,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              up_ready,
  output logic [DATA_W-1:0] up_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic              dn_is_byte,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_ready,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              coproc_rst
);
  localparam logic [OFFS_W-1:0] OFF_LO = OFFS_W'(BASE);
  localparam logic [OFFS_W-1:0] OFF_HI = OFFS_W'(BASE) | OFFS_W'(1);

  logic [OFFS_W-1:0] off;
  logic              hit_rst_b, hit_vm_b, hit_pair, hit_any, wen;
  logic [7:0]        vmode;
  logic              rst_bit;
  logic [DATA_W-1:0] local_rd;

  assign off       = up_addr[OFFS_W-1:0];
  assign hit_rst_b = up_is_byte  && (off == OFF_LO);
  assign hit_vm_b  = up_is_byte  && (off == OFF_HI);
  assign hit_pair  = !up_is_byte && (off == OFF_LO);
  assign hit_any   = hit_rst_b || hit_vm_b || hit_pair;
  assign wen       = up_valid && up_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      vmode   <= 8'h00;
      rst_bit <= 1'b0;
    end else if (wen) begin
      if (hit_vm_b) vmode <= up_wdata[7:0];
      if (hit_rst_b) rst_bit <= up_wdata[0];
      if (hit_pair) begin
        vmode   <= up_wdata[15:8];
        rst_bit <= up_wdata[0];
      end
    end
  end

  always_comb begin
    if (hit_vm_b)       local_rd = DATA_W'(vmode);
    else if (hit_rst_b) local_rd = DATA_W'(rst_bit);
    else                local_rd = DATA_W'({vmode, 7'b0, rst_bit});
  end

  assign up_rdata   = hit_any ? local_rd : dn_rdata;
  assign up_ready   = hit_any ? 1'b1 : dn_ready;
  assign dn_valid   = up_valid && !hit_any;
  assign dn_write   = up_write;
  assign dn_is_byte = up_is_byte;
  assign dn_addr    = ADDR_W'(off);
  assign dn_wdata   = up_wdata;
  assign coproc_rst = rst_bit;
endmodule

// File: rtl/ctl_alias_slice_chk.sv
module ctl_alias_slice_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              up_valid,
  input logic              up_write,
  input logic              up_is_byte,
  input logic [ADDR_W-1:0] up_addr,
  input logic [DATA_W-1:0] up_wdata,
  input logic              up_ready,
  input logic [DATA_W-1:0] up_rdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [DATA_W-1:0] dn_rdata,
  input logic              coproc_rst
);
  logic at_lo, at_hi, loc, rwr, was_rst;
  assign at_lo = (up_addr[14:0] == 15'h2C00);
  assign at_hi = (up_addr[14:0] == 15'h2C01);
  assign loc   = at_lo || (up_is_byte && at_hi);
  assign rwr   = up_valid && up_write && at_lo;

  always_ff @(posedge clk) was_rst <= rst;

  always @(posedge clk)
    if (!rst && was_rst)
      AST_RESET_ZERO: assert (coproc_rst == 1'b0) else $error("reset bit not cleared"); // R9

  AST_LOCAL_QUIET: assert property (@(posedge clk) disable iff (rst) up_valid && loc |-> !dn_valid && up_ready); // R8
  AST_PASS_HANDSHAKE: assert property (@(posedge clk) disable iff (rst) up_valid && !loc |-> dn_valid && (up_ready == dn_ready)); // R7
  AST_PASS_RDATA: assert property (@(posedge clk) disable iff (rst) up_valid && !loc && !up_write |-> up_rdata == dn_rdata); // R7
  AST_RST_LOAD: assert property (@(posedge clk) disable iff (rst) rwr |=> coproc_rst == $past(up_wdata[0])); // R6
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst) !rwr |=> $stable(coproc_rst)); // R6
  AST_RST_READBACK: assert property (@(posedge clk) disable iff (rst) up_valid && !up_write && up_is_byte && at_lo |-> up_rdata == DATA_W'(coproc_rst)); // R3
endmodule

bind ctl_alias_slice ctl_alias_slice_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .up_valid(up_valid), .up_write(up_write), .up_is_byte(up_is_byte),
  .up_addr(up_addr), .up_wdata(up_wdata), .up_ready(up_ready), .up_rdata(up_rdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_rdata(dn_rdata), .coproc_rst(coproc_rst)
);

// File: tb/test_ctl_alias_slice.sv
module test_ctl_alias_slice;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_valid = 1'b0, up_write = 1'b0, up_is_byte = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic        up_ready;
  logic [31:0] up_rdata;
  logic        dn_valid, dn_write, dn_is_byte;
  logic [31:0] dn_addr, dn_wdata;
  logic        dn_ready = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic        coproc_rst;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_vm = 8'h00;
  logic       m_rb = 1'b0;

  always #2 clk = ~clk;

  ctl_alias_slice i_ctl_alias_slice (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_write(up_write), .up_is_byte(up_is_byte),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_ready(up_ready), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_is_byte(dn_is_byte), .dn_addr(dn_addr),
    .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rdata(dn_rdata), .coproc_rst(coproc_rst)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_local(input bit byte_, input logic [31:0] a);
    return (a[14:0] == 15'h2C00) || (byte_ && a[14:0] == 15'h2C01);
  endfunction

  function automatic logic [31:0] exp_local(input bit byte_, input logic [31:0] a);
    if (byte_ && a[14:0] == 15'h2C01) return {24'h0, m_vm};
    if (byte_) return {31'h0, m_rb};
    return {16'h0, m_vm, 7'h0, m_rb};
  endfunction

  task automatic access(input bit w, input bit byte_, input logic [31:0] a, input logic [31:0] d,
                        input bit rdy, input logic [31:0] drd, input string req);
    @(negedge clk);
    up_valid = 1'b1; up_write = w; up_is_byte = byte_; up_addr = a; up_wdata = d;
    dn_ready = rdy; dn_rdata = drd;
    #1;
    if (is_local(byte_, a)) begin
      check(up_ready === 1'b1, "R8 ready", {31'h0, up_ready}, 32'h1);
      check(dn_valid === 1'b0, "R8 dn_valid", {31'h0, dn_valid}, 32'h0);
      if (!w) check(up_rdata === exp_local(byte_, a), req, up_rdata, exp_local(byte_, a));
    end else begin
      check(dn_valid === 1'b1, "R7 dn_valid", {31'h0, dn_valid}, 32'h1);
      check(dn_addr === {17'h0, a[14:0]}, "R1 dn_addr", dn_addr, {17'h0, a[14:0]});
      check({dn_write, dn_is_byte} === {w, byte_}, "R7 attrs", {30'h0, dn_write, dn_is_byte}, {30'h0, w, byte_});
      check(dn_wdata === d, "R7 wdata", dn_wdata, d);
      check(up_ready === rdy, "R7 ready", {31'h0, up_ready}, {31'h0, rdy});
      if (!w) check(up_rdata === drd, "R7 rdata", up_rdata, drd);
    end
    @(posedge clk);
    if (w && a[14:0] == 15'h2C00 && !byte_) begin m_vm = d[15:8]; m_rb = d[0]; end
    else if (w && a[14:0] == 15'h2C00) m_rb = d[0];
    else if (w && byte_ && a[14:0] == 15'h2C01) m_vm = d[7:0];
    #1;
    check(coproc_rst === m_rb, "R6 coproc_rst", {31'h0, coproc_rst}, {31'h0, m_rb});
    up_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check(coproc_rst === 1'b0, "R9 reset", {31'h0, coproc_rst}, 32'h0);
    access(0, 0, 32'h0000_2C00, 0, 0, 32'hDEAD_BEEF, "R9 packed read after reset");
    access(1, 1, 32'h0000_2C01, 32'h0000_00A5, 0, 0, "R2 write");
    access(0, 1, 32'h0000_2C01, 0, 0, 32'h1111_1111, "R2 read");
    access(1, 1, 32'h0000_2C00, 32'h0000_00FF, 0, 0, "R3 write");
    access(0, 1, 32'h0000_2C00, 0, 0, 0, "R3 read reduced");
    access(0, 0, 32'h0000_2C00, 0, 1, 0, "R4 packed read");
    access(1, 0, 32'h0000_2C00, 32'hFFFF_3C02, 0, 0, "R5 packed write");
    access(0, 1, 32'h0000_2C01, 0, 0, 0, "R5 vmode after packed write");
    access(0, 0, 32'h0000_2C00, 0, 0, 0, "R4 packed read back");
    access(1, 0, 32'h0000_2C01, 32'h0000_FFFF, 1, 0, "R7 non-byte at 2C01");
    access(0, 0, 32'h0000_2C01, 0, 0, 32'hCAFE_F00D, "R7 non-byte read 2C01 stalled");
    access(1, 1, 32'hFFFF_AC00, 32'h0000_0001, 0, 0, "R1 upper bits set write");
    access(0, 1, 32'h1234_AC00, 0, 0, 0, "R1 upper bits set read");
    access(0, 1, 32'h0000_2C02, 0, 1, 32'h0000_0077, "R7 neighbour offset");
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = $urandom;
      if (sel == 0) a[14:0] = 15'h2C00;
      else if (sel == 1) a[14:0] = 15'h2C01;
      else if (sel == 2) a[14:0] = 15'h2C02;
      access(1'($urandom), 1'($urandom), a, $urandom, 1'($urandom), $urandom, "R4 random local read");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule